// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable single-port synchronous memory whose read and write commands can be mixed in any order on consecutive clock edges without idle cycles in between. Each command (address, direction and byte mask) is captured on a rising edge and travels down a two-stage pipeline, so the data belonging to a command moves on the data bus two enabled edges later, whether it is a read or a write. Because write data arrives on the same schedule as read data, a write followed by a read, or a read followed by a write, never collides on the bus.

An internal burst counter lets one loaded address drive four accesses. Continuation cycles walk the low two address bits in either linear or interleaved order, chosen on the load cycle. A clock enable freezes the entire block as if the edge never occurred, and an asynchronous output enable gates the bus driver. The shared bus is split into an input, an output and a drive-enable so that the pad ring above can form the bidirectional pin.

Top module: `nobubble_sram`

## Requirements
- R1: A command is captured on a rising edge where `cke_n`=0, `adv_nload`=0 and the chip is selected. Selected means `sel1_n`=0, `sel2_n`=0 and `sel_hi`=1. With `rd_nwr`=1 (read), the word at `addr` appears on `dq_out` with `dq_oe`=1 from the second enabled rising edge after the capture edge until the next enabled edge.
- R2: With `rd_nwr`=0 (write), `dq_in` is sampled on the second enabled rising edge after the command. Byte k (bits 9k+8..9k) is stored only when `bwe_n[k]`=0 on the command or beat cycle.
- R3: With `adv_nload`=0, any chip-enable combination other than the selected one is a deselect. It makes no access, ends any burst, and leaves `dq_oe`=0 after the second following enabled edge.
- R4: A write command leaves `dq_oe`=0 after the second following enabled edge. `bwe_n` has no effect on read commands, and memory contents are unchanged by them.
- R5: With `adv_nload`=1 during an active burst, the next beat accesses the loaded address with its low two bits replaced. In linear order (`burst_il`=0 on the load cycle) they become (base+n) mod 4; in interleaved order (`burst_il`=1) they become base XOR n, for n=1,2,3. The direction comes from the load cycle, and `rd_nwr`, `addr` and later `burst_il` values are ignored on beats.
- R6: With `adv_nload`=1 and no burst active (after reset or a deselect), no access is made and `dq_oe`=0 two enabled edges later.
- R7: A rising edge with `cke_n`=1 is ignored. All inputs are disregarded, outputs and pipeline hold, and the memory is not written.
- R8: A read issued one or two commands after a write to the same address returns the newly written bytes merged with the untouched old bytes.
- R9: `oe_n`=1 forces `dq_oe`=0 at once, without a clock edge. Returning it to 0 restores the driver with the held data.
- R10: `rst`=1 on a rising edge clears the pipeline and burst state, so `dq_oe`=0 afterwards and an in-flight read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_n | input | 1 | Clock enable, active low |
| sel1_n | input | 1 | Chip enable, active low |
| sel2_n | input | 1 | Second chip enable, active low |
| sel_hi | input | 1 | Chip enable, active high |
| adv_nload | input | 1 | 0 = load new command, 1 = advance burst |
| rd_nwr | input | 1 | 1 = read, 0 = write (load cycles) |
| burst_il | input | 1 | 1 = interleaved, 0 = linear burst order |
| bwe_n | input | NUM_BYTES | Per-byte write enables, active low |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | DATA_W | Write data from the bus |
| dq_out | output | DATA_W | Read data to the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The hardest case to reach is a read whose data must come from a write that has not yet reached the array. This happens when the write lands on the array in the same edge as the read's array access. The stimulus gets there by closing a four-beat write burst and loading a read of its final beat's address on the very next cycle. It also follows a masked write with reads at distances one and two, so that both the bypass path and the array path must merge the bytes correctly. Freeze cycles with garbage inputs and an advance issued while no burst is active are then checked by reading back the addresses they could have corrupted.

// File: rtl/nbs_pkg.sv
`timescale 1ns/1ps
package nbs_pkg;

    // Operation carried through the command pipeline.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Low address bits of a burst beat: linear wraps a sum, interleaved flips bits.
    function automatic int unsigned beat_offset(
        input int unsigned base_lo,
        input int unsigned beat,
        input logic        interleave,
        input int unsigned span
    );
        if (interleave) begin
            return (base_lo ^ beat) % span;
        end
        return (base_lo + beat) % span;
    endfunction

    // The only enable combination that addresses the device.
    function automatic logic chip_selected(
        input logic en_a_n,
        input logic en_b_n,
        input logic en_c
    );
        return !en_a_n && !en_b_n && en_c;
    endfunction

endpackage

// File: rtl/nbs_cmd_ctl.sv
`timescale 1ns/1ps
module nbs_cmd_ctl
    import nbs_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int NUM_BYTES  = 4,
    parameter int BURST_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 adv_nload,
    input  logic                 rd_nwr,
    input  logic                 sel1_n,
    input  logic                 sel2_n,
    input  logic                 sel_hi,
    input  logic                 burst_il,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_BYTES-1:0] bwe_n,
    output op_e                  cmd_op,
    output logic [ADDR_W-1:0]    cmd_addr,
    output logic [NUM_BYTES-1:0] cmd_bwe_n
);

    localparam int unsigned SPAN = 1 << BURST_BITS;

    logic                  selected;
    logic                  burst_active;
    logic                  burst_write;
    logic                  burst_order_q;
    logic [ADDR_W-1:0]     base_addr;
    logic [BURST_BITS-1:0] beat;
    logic [BURST_BITS-1:0] next_beat;
    logic [BURST_BITS-1:0] beat_lo;

    assign selected  = chip_selected(sel1_n, sel2_n, sel_hi);
    assign next_beat = beat + BURST_BITS'(1);
    assign beat_lo   = BURST_BITS'(beat_offset(32'(base_addr[BURST_BITS-1:0]),
                                               32'(next_beat), burst_order_q, SPAN));

    always_ff @(posedge clk) begin
        if (rst) begin
            burst_active  <= 1'b0;
            burst_write   <= 1'b0;
            burst_order_q <= 1'b0;
            base_addr     <= '0;
            beat          <= '0;
            cmd_op        <= OP_IDLE;
            cmd_addr      <= '0;
            cmd_bwe_n     <= '1;
        end else if (en) begin
            if (!adv_nload) begin
                if (selected) begin
                    burst_active  <= 1'b1;
                    burst_write   <= !rd_nwr;
                    burst_order_q <= burst_il;
                    base_addr     <= addr;
                    beat          <= '0;
                    cmd_op        <= rd_nwr ? OP_READ : OP_WRITE;
                    cmd_addr      <= addr;
                    cmd_bwe_n     <= rd_nwr ? '1 : bwe_n;
                end else begin
                    burst_active  <= 1'b0;
                    cmd_op        <= OP_IDLE;
                    cmd_bwe_n     <= '1;
                end
            end else if (burst_active) begin
                beat      <= next_beat;
                cmd_op    <= burst_write ? OP_WRITE : OP_READ;
                cmd_addr  <= {base_addr[ADDR_W-1:BURST_BITS], beat_lo};
                cmd_bwe_n <= burst_write ? bwe_n : '1;
            end else begin
                cmd_op    <= OP_IDLE;
                cmd_bwe_n <= '1;
            end
        end
    end

    AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (rst)
        (en && !adv_nload && selected) |=> (cmd_addr == $past(addr) && cmd_op != OP_IDLE)); // R1
    AST_DESELECT_ENDS_BURST: assert property (@(posedge clk) disable iff (rst)
        (en && !adv_nload && !selected) |=> (cmd_op == OP_IDLE && !burst_active)); // R3
    AST_IDLE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (en && adv_nload && !burst_active) |=> (cmd_op == OP_IDLE)); // R6

endmodule

// File: rtl/nbs_array.sv
`timescale 1ns/1ps
module nbs_array #(
    parameter int ADDR_W    = 8,
    parameter int NUM_BYTES = 4,
    parameter int BYTE_W    = 9
) (
    input  logic                        clk,
    input  logic                        en,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           rd_addr,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [NUM_BYTES-1:0]        wr_bwe_n,
    input  logic [NUM_BYTES*BYTE_W-1:0] wr_data,
    output logic [NUM_BYTES*BYTE_W-1:0] rd_data
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = NUM_BYTES * BYTE_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Synchronous read port; a same-edge write is not visible here (bypass covers it).
    always_ff @(posedge clk) begin
        if (en && rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (en && wr_en) begin
            for (int b = 0; b < NUM_BYTES; b++) begin
                if (!wr_bwe_n[b]) begin
                    mem[wr_addr][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
                end
            end
        end
    end

endmodule

// File: rtl/nbs_fwd.sv
`timescale 1ns/1ps
module nbs_fwd #(
    parameter int ADDR_W    = 8,
    parameter int NUM_BYTES = 4,
    parameter int BYTE_W    = 9
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        en,
    input  logic                        wr_valid,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [NUM_BYTES-1:0]        wr_bwe_n,
    input  logic [NUM_BYTES*BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    input  logic [NUM_BYTES*BYTE_W-1:0] rd_raw,
    output logic [NUM_BYTES*BYTE_W-1:0] rd_merged
);

    localparam int DATA_W = NUM_BYTES * BYTE_W;

    logic                 lw_valid;
    logic [ADDR_W-1:0]    lw_addr;
    logic [NUM_BYTES-1:0] lw_bwe_n;
    logic [DATA_W-1:0]    lw_data;
    logic                 hit;

    // Remembers the write committed on the same edge as the pending read's array access.
    always_ff @(posedge clk) begin
        if (rst) begin
            lw_valid <= 1'b0;
            lw_addr  <= '0;
            lw_bwe_n <= '1;
            lw_data  <= '0;
        end else if (en) begin
            lw_valid <= wr_valid;
            lw_addr  <= wr_addr;
            lw_bwe_n <= wr_bwe_n;
            lw_data  <= wr_data;
        end
    end

    assign hit = lw_valid && (lw_addr == rd_addr);

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
        assign rd_merged[b*BYTE_W +: BYTE_W] = (hit && !lw_bwe_n[b])
                                              ? lw_data[b*BYTE_W +: BYTE_W]
                                              : rd_raw[b*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/nobubble_sram.sv
`timescale 1ns/1ps
module nobubble_sram
    import nbs_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int BYTE_W     = 9,
    parameter int NUM_BYTES  = 4,
    parameter int BURST_BITS = 2,
    localparam int DATA_W    = BYTE_W * NUM_BYTES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cke_n,
    input  logic                 sel1_n,
    input  logic                 sel2_n,
    input  logic                 sel_hi,
    input  logic                 adv_nload,
    input  logic                 rd_nwr,
    input  logic                 burst_il,
    input  logic [NUM_BYTES-1:0] bwe_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 oe_n,
    input  logic [DATA_W-1:0]    dq_in,
    output logic [DATA_W-1:0]    dq_out,
    output logic                 dq_oe
);

    typedef struct packed {
        op_e                  op;
        logic [ADDR_W-1:0]    addr;
        logic [NUM_BYTES-1:0] bwe_n;
    } stage_t;

    logic              en;
    stage_t            s1;
    stage_t            s2;
    logic [DATA_W-1:0] rd_raw;
    logic [DATA_W-1:0] rd_merged;
    logic              rd_valid_q;
    logic [DATA_W-1:0] dout_q;

    assign en = !cke_n;

    nbs_cmd_ctl #(
        .ADDR_W    (ADDR_W),
        .NUM_BYTES (NUM_BYTES),
        .BURST_BITS(BURST_BITS)
    ) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .adv_nload(adv_nload),
        .rd_nwr   (rd_nwr),
        .sel1_n   (sel1_n),
        .sel2_n   (sel2_n),
        .sel_hi   (sel_hi),
        .burst_il (burst_il),
        .addr     (addr),
        .bwe_n    (bwe_n),
        .cmd_op   (s1.op),
        .cmd_addr (s1.addr),
        .cmd_bwe_n(s1.bwe_n)
    );

    // Second pipeline stage: the command whose data moves on the next enabled edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            s2 <= '{op: OP_IDLE, addr: '0, bwe_n: '1};
        end else if (en) begin
            s2 <= s1;
        end
    end

    nbs_array #(
        .ADDR_W   (ADDR_W),
        .NUM_BYTES(NUM_BYTES),
        .BYTE_W   (BYTE_W)
    ) u_array (
        .clk     (clk),
        .en      (en),
        .rd_en   (s1.op == OP_READ),
        .rd_addr (s1.addr),
        .wr_en   (s2.op == OP_WRITE),
        .wr_addr (s2.addr),
        .wr_bwe_n(s2.bwe_n),
        .wr_data (dq_in),
        .rd_data (rd_raw)
    );

    nbs_fwd #(
        .ADDR_W   (ADDR_W),
        .NUM_BYTES(NUM_BYTES),
        .BYTE_W   (BYTE_W)
    ) u_fwd (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .wr_valid (s2.op == OP_WRITE),
        .wr_addr  (s2.addr),
        .wr_bwe_n (s2.bwe_n),
        .wr_data  (dq_in),
        .rd_addr  (s2.addr),
        .rd_raw   (rd_raw),
        .rd_merged(rd_merged)
    );

    // Pipelined output register: loads read data, releases the bus for anything else.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
            dout_q     <= '0;
        end else if (en) begin
            rd_valid_q <= (s2.op == OP_READ);
            if (s2.op == OP_READ) begin
                dout_q <= rd_merged;
            end
        end
    end

    assign dq_out = dout_q;
    assign dq_oe  = rd_valid_q & ~oe_n;

    AST_WRITE_RELEASES_BUS: assert property (@(posedge clk) disable iff (rst)
        (en && s2.op == OP_WRITE) |=> !rd_valid_q); // R4
    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(rd_valid_q) && $stable(dout_q) && $stable(s2))); // R7

endmodule

// File: tb/nobubble_sram_bench.sv
`timescale 1ns/1ps
module nobubble_sram_bench;

    localparam logic L = 1'b0;
    localparam logic H = 1'b1;

    localparam logic [35:0] ZD = 36'h0_0000_0000;
    localparam logic [35:0] GG = 36'hF_FFFF_FFFF;
    localparam logic [35:0] W0 = 36'h1_2345_6789;
    localparam logic [35:0] W1 = 36'hA_BCDE_F012;
    localparam logic [35:0] W2 = 36'h5_5555_5555;
    localparam logic [35:0] M1 = {W1[35:18], W2[17:0]};
    localparam logic [35:0] B0 = 36'h0_B0B0_B0B0;
    localparam logic [35:0] B1 = 36'h1_B1B1_B1B1;
    localparam logic [35:0] B2 = 36'h2_B2B2_B2B2;
    localparam logic [35:0] B3 = 36'h3_B3B3_B3B3;

    typedef struct packed {
        logic        cke;
        logic        s1n;
        logic        s2n;
        logic        shi;
        logic        adv;
        logic        rnw;
        logic        il;
        logic [3:0]  bwe;
        logic [7:0]  addr;
        logic [35:0] din;
        logic        eoe;
        logic [35:0] edq;
    } vec_t;

    localparam int NV = 36;
    // cke s1n s2n shi adv rnw il bwe addr din | expected oe, dq after this edge
    localparam vec_t VECS [NV] = '{
        '{L,L,L,H,L,L,L,4'h0,8'h10,ZD,L,ZD},
        '{L,L,L,H,L,L,L,4'h0,8'h11,ZD,L,ZD},
        '{L,L,L,H,L,H,L,4'hF,8'h10,W0,L,ZD},
        '{L,L,L,H,L,H,L,4'hF,8'h11,W1,L,ZD},
        '{L,L,L,H,L,L,L,4'hC,8'h11,ZD,H,W0},
        '{L,L,L,H,L,H,L,4'hF,8'h11,ZD,H,W1},
        '{L,L,L,H,L,H,L,4'hF,8'h11,W2,L,ZD},
        '{L,L,L,L,L,H,L,4'hF,8'h10,ZD,H,M1},
        '{L,L,H,H,L,H,L,4'hF,8'h10,ZD,H,M1},
        '{L,L,L,H,L,H,L,4'h0,8'h11,ZD,L,ZD},
        '{L,H,L,H,L,H,L,4'hF,8'h00,GG,L,ZD},
        '{L,H,L,H,L,H,L,4'hF,8'h00,ZD,H,M1},
        '{L,L,L,H,L,L,L,4'h0,8'h22,ZD,L,ZD},
        '{L,L,L,H,H,H,L,4'h0,8'h00,ZD,L,ZD},
        '{L,L,L,H,H,L,L,4'h0,8'h00,B0,L,ZD},
        '{L,L,L,H,H,L,L,4'h0,8'h00,B1,L,ZD},
        '{L,L,L,H,L,H,L,4'hF,8'h21,B2,L,ZD},
        '{L,L,L,H,H,H,L,4'hF,8'h00,B3,L,ZD},
        '{L,L,L,H,H,H,L,4'hF,8'h00,ZD,H,B3},
        '{L,L,L,H,H,H,L,4'hF,8'h00,ZD,H,B0},
        '{L,L,L,H,L,H,H,4'hF,8'h21,ZD,H,B1},
        '{L,L,L,H,H,H,L,4'hF,8'h00,ZD,H,B2},
        '{L,L,L,H,H,H,L,4'hF,8'h00,ZD,H,B3},
        '{L,L,L,H,H,H,L,4'hF,8'h00,ZD,H,B2},
        '{H,L,L,H,L,L,L,4'h0,8'h22,GG,H,B2},
        '{H,L,L,H,L,H,L,4'hF,8'h10,GG,H,B2},
        '{L,H,H,L,L,H,L,4'hF,8'h00,ZD,H,B1},
        '{L,H,L,H,L,H,L,4'hF,8'h00,ZD,H,B0},
        '{L,H,L,H,L,H,L,4'hF,8'h00,ZD,L,ZD},
        '{L,L,L,H,H,L,L,4'h0,8'h22,ZD,L,ZD},
        '{L,L,L,H,L,H,L,4'hF,8'h22,ZD,L,ZD},
        '{L,L,L,H,H,H,L,4'hF,8'h00,GG,L,ZD},
        '{L,H,L,H,L,H,L,4'hF,8'h00,ZD,H,B0},
        '{L,L,L,H,L,H,L,4'hF,8'h11,ZD,H,B1},
        '{L,H,L,H,L,H,L,4'hF,8'h00,ZD,L,ZD},
        '{L,H,L,H,L,H,L,4'hF,8'h00,ZD,H,M1}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        cke_n, sel1_n, sel2_n, sel_hi, adv_nload, rd_nwr, burst_il, oe_n;
    logic [3:0]  bwe_n;
    logic [7:0]  addr;
    logic [35:0] dq_in;
    logic [35:0] dq_out;
    logic        dq_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    nobubble_sram u_nobubble_sram (
        .clk      (clk),
        .rst      (rst),
        .cke_n    (cke_n),
        .sel1_n   (sel1_n),
        .sel2_n   (sel2_n),
        .sel_hi   (sel_hi),
        .adv_nload(adv_nload),
        .rd_nwr   (rd_nwr),
        .burst_il (burst_il),
        .bwe_n    (bwe_n),
        .addr     (addr),
        .oe_n     (oe_n),
        .dq_in    (dq_in),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );

    function automatic string tag(int i);
        if (i <= 3)  return "R1 R2 R4";
        if (i <= 6)  return "R1 R2 R8";
        if (i <= 8)  return "R2 R3 R8";
        if (i <= 11) return "R3 R4";
        if (i <= 17) return "R5 R2";
        if (i <= 19) return "R5 R8";
        if (i <= 23) return "R5";
        if (i <= 28) return "R7";
        if (i <= 31) return "R6";
        if (i <= 33) return "R7 R6";
        return "R4";
    endfunction

    task automatic check(string t, logic got_oe, logic exp_oe,
                         logic [35:0] got, logic [35:0] exp);
        n_checks++;
        if (got_oe !== exp_oe || (exp_oe && got !== exp)) begin
            n_fail++;
            $display("FAIL %s: dq_oe=%0b dq_out=%h, expected dq_oe=%0b dq_out=%h",
                     t, got_oe, got, exp_oe, exp);
        end
    endtask

    task automatic apply(vec_t v);
        cke_n     = v.cke;
        sel1_n    = v.s1n;
        sel2_n    = v.s2n;
        sel_hi    = v.shi;
        adv_nload = v.adv;
        rd_nwr    = v.rnw;
        burst_il  = v.il;
        bwe_n     = v.bwe;
        addr      = v.addr;
        dq_in     = v.din;
    endtask

    task automatic deselect();
        apply('{L,H,L,H,L,H,L,4'hF,8'h00,ZD,L,ZD});
    endtask

    initial begin
        rst = 1'b1;
        oe_n = 1'b0;
        deselect();
        repeat (2) @(posedge clk);
        #5 check("R10 reset", dq_oe, 1'b0, dq_out, ZD);
        @(negedge clk) rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VECS[i]);
            @(posedge clk);
            #5 check(tag(i), dq_oe, VECS[i].eoe, dq_out, VECS[i].edq);
        end

        // Read 0x10, then gate the driver asynchronously while frozen (R9, R7).
        @(negedge clk) apply('{L,L,L,H,L,H,L,4'hF,8'h10,ZD,L,ZD});
        @(negedge clk) deselect();
        @(negedge clk);
        @(posedge clk);
        #5 check("R1 directed read", dq_oe, 1'b1, dq_out, W0);
        @(negedge clk);
        cke_n = 1'b1;
        oe_n  = 1'b1;
        #1 check("R9 oe_n high", dq_oe, 1'b0, dq_out, ZD);
        oe_n = 1'b0;
        #1 check("R9 oe_n low", dq_oe, 1'b1, dq_out, W0);
        @(posedge clk);
        #5 check("R7 frozen edge", dq_oe, 1'b1, dq_out, W0);
        @(negedge clk) cke_n = 1'b0;

        // Reset while a read is in flight drops it (R10).
        @(negedge clk) apply('{L,L,L,H,L,H,L,4'hF,8'h11,ZD,L,ZD});
        @(negedge clk);
        deselect();
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #5 check("R10 in-flight read dropped", dq_oe, 1'b0, dq_out, ZD);
        @(negedge clk) rst = 1'b0;
        @(posedge clk);
        #5 check("R10 after release", dq_oe, 1'b0, dq_out, ZD);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule